// File: doc/BRIEF.md
# Partial Array Self-Refresh Sequencer

This block produces the internal refresh strobes for a four-bank memory while the memory sits in self refresh. Each strobe carries a bank and row address. Only the part of the array chosen by a retention code gets strobes, which keeps self-refresh current low. Rows outside the retained part are never addressed. A free-running interval timer paces the strobes. Its period follows a two-bit temperature code, so the refresh rate tracks temperature without any host write to a mode register.

The retained region always begins at bank 0, row 0, and grows upward through the linear index `bank * ROWS + row`:
- full array: four banks
- half: banks 0 and 1
- quarter: bank 0
- eighth: lower half of bank 0
- sixteenth: lower quarter of bank 0

A position counter walks this index and wraps at the end of the region. The counter keeps its value while self refresh is off, so the next entry resumes where the last one stopped.

Top module: `sr_pasr_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ref_stb` is 0 and `ref_bank`/`ref_row` are 0. The position counter restarts at bank 0, row 0.
- R2: `pa_code` selects the retained region. Code 0 selects the full array, 4*ROWS locations. Code 1 selects half, banks 0–1. Code 2 selects a quarter, bank 0. Code 3 selects an eighth, rows below ROWS/2 of bank 0. Code 4 selects a sixteenth, rows below ROWS/4 of bank 0. Codes 5–7 act as full. Every strobe addresses a location inside the region selected by the `pa_code` value sampled on the edge that issues it.
- R3: Successive strobes step the linear index `ref_bank*ROWS + ref_row` up by one. The bank advances after row ROWS-1.
- R4: After the last location of the region, the next strobe addresses bank 0, row 0.
- R5: If the stored position lies outside the region, for example after `pa_code` narrows, the next strobe addresses bank 0, row 0.
- R6: The strobe period follows `temp_code`. Code 0 (coldest) gives 4*BASE_TICKS cycles, code 1 gives 2*BASE_TICKS, code 2 gives BASE_TICKS and code 3 (hottest) gives BASE_TICKS/2. The first strobe after entry appears that many cycles after `sr_en` is first sampled high.
- R7: A change of `temp_code` takes effect at once. If the cycles already counted reach the new period, a strobe is issued on the next edge.
- R8: After `sr_en` is sampled low, `ref_stb` is 0 from the next cycle on. On re-entry the interval count starts again from zero.
- R9: The position counter keeps its value while `sr_en` is low. The first strobe after re-entry continues the sequence.
- R10: `ref_bank` and `ref_row` change only in cycles where `ref_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_en | input | 1 | Self refresh active |
| pa_code | input | 3 | Retained-region selection code |
| temp_code | input | 2 | Temperature band, 0 coldest to 3 hottest |
| ref_stb | output | 1 | One-cycle refresh strobe |
| ref_bank | output | 2 | Bank of the current refresh |
| ref_row | output | ROW_W | Row of the current refresh |

## Verification
The hardest case to reach is a narrowed region that leaves the stored position outside the retained part, as R5 describes. The position has to be pushed high in the full array first, which takes hundreds of strobes. The bench reaches it with a directed run at the hottest temperature code that steps the position into bank 2 and then switches to the quarter code. Random segments then mix region codes, temperature changes within an interval, and exits and re-entries against a cycle model of the requirements.

// File: rtl/sr_pasr_pkg.sv
package sr_pasr_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;

    typedef enum logic [2:0] {
        PA_FULL      = 3'd0,
        PA_HALF      = 3'd1,
        PA_QUARTER   = 3'd2,
        PA_EIGHTH    = 3'd3,
        PA_SIXTEENTH = 3'd4
    } pa_sel_e;

    typedef enum logic [1:0] {
        TEMP_COLD = 2'd0,
        TEMP_COOL = 2'd1,
        TEMP_WARM = 2'd2,
        TEMP_HOT  = 2'd3
    } temp_band_e;

    // Number of linear locations kept alive for a retention code.
    function automatic int region_span(logic [2:0] code, int rows);
        case (code)
            PA_HALF:      return 2 * rows;
            PA_QUARTER:   return rows;
            PA_EIGHTH:    return rows / 2;
            PA_SIXTEENTH: return rows / 4;
            default:      return NUM_BANKS * rows;
        endcase
    endfunction

    // Strobe period in clock cycles for a temperature band.
    function automatic int tick_interval(logic [1:0] band, int base);
        case (band)
            TEMP_COLD: return 4 * base;
            TEMP_COOL: return 2 * base;
            TEMP_WARM: return base;
            default:   return (base / 2 < 1) ? 1 : base / 2;
        endcase
    endfunction

endpackage

// File: rtl/sr_tick_timer.sv
module sr_tick_timer
    import sr_pasr_pkg::*;
#(
    parameter int BASE_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] band,
    output logic       tick
);

    localparam int TMR_W = $clog2(4 * BASE_TICKS + 1);

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] last_cnt;

    always_comb begin
        last_cnt = TMR_W'(tick_interval(band, BASE_TICKS) - 1);
    end

    // Greater-or-equal so a shorter period after a band change fires at once.
    assign tick = run && (cnt_q >= last_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sr_row_seq.sv
module sr_row_seq
    import sr_pasr_pkg::*;
#(
    parameter int ROW_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [2:0]        pa_code,
    output logic              stb,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);

    localparam int ROWS   = 1 << ROW_W;
    localparam int IDX_W  = BANK_W + ROW_W;
    localparam int SPAN_W = IDX_W + 1;

    logic [IDX_W-1:0]  pos_q;
    logic [IDX_W-1:0]  eff;
    logic [IDX_W-1:0]  nxt;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] eff_inc;

    always_comb begin
        span    = SPAN_W'(region_span(pa_code, ROWS));
        // A position left outside a narrowed region restarts at the base.
        eff     = ({1'b0, pos_q} >= span) ? '0 : pos_q;
        eff_inc = {1'b0, eff} + 1'b1;
        nxt     = (eff_inc >= span) ? '0 : eff_inc[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            stb   <= 1'b0;
            bank  <= '0;
            row   <= '0;
        end else begin
            stb <= tick;
            if (tick) begin
                {bank, row} <= eff;
                pos_q       <= nxt;
            end
        end
    end

endmodule

// File: rtl/sr_pasr_ctrl.sv
module sr_pasr_ctrl
    import sr_pasr_pkg::*;
#(
    parameter int ROW_W      = 6,
    parameter int BASE_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sr_en,
    input  logic [2:0]       pa_code,
    input  logic [1:0]       temp_code,
    output logic             ref_stb,
    output logic [1:0]       ref_bank,
    output logic [ROW_W-1:0] ref_row
);

    logic tick;

    sr_tick_timer #(
        .BASE_TICKS (BASE_TICKS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (sr_en),
        .band (temp_code),
        .tick (tick)
    );

    sr_row_seq #(
        .ROW_W (ROW_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .pa_code (pa_code),
        .stb     (ref_stb),
        .bank    (ref_bank),
        .row     (ref_row)
    );

endmodule

// File: rtl/sr_pasr_ctrl_chk.sv
module sr_pasr_ctrl_chk
    import sr_pasr_pkg::*;
#(
    parameter int ROW_W      = 6,
    parameter int BASE_TICKS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sr_en,
    input logic [2:0]       pa_code,
    input logic [1:0]       temp_code,
    input logic             ref_stb,
    input logic [1:0]       ref_bank,
    input logic [ROW_W-1:0] ref_row
);

    localparam int ROWS = 1 << ROW_W;

    logic [2:0] pa_q;
    int         span_prev;
    int         idx_now;

    always_ff @(posedge clk) begin
        pa_q <= pa_code;
    end

    always_comb begin
        span_prev = region_span(pa_q, ROWS);
        idx_now   = int'({ref_bank, ref_row});
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!ref_stb && ref_bank == 2'd0 && ref_row == '0));

    // R8
    exit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sr_en |=> !ref_stb);

    // R2
    in_region_chk: assert property (@(posedge clk) disable iff (rst)
        ref_stb |-> (idx_now < span_prev));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_stb |-> $stable({ref_bank, ref_row}));

endmodule

bind sr_pasr_ctrl sr_pasr_ctrl_chk #(
    .ROW_W      (ROW_W),
    .BASE_TICKS (BASE_TICKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sr_en     (sr_en),
    .pa_code   (pa_code),
    .temp_code (temp_code),
    .ref_stb   (ref_stb),
    .ref_bank  (ref_bank),
    .ref_row   (ref_row)
);

// File: tb/sr_pasr_ctrl_tb.sv
`timescale 1ns/1ps
module sr_pasr_ctrl_tb;

    localparam int ROW_W = 6;
    localparam int BASE  = 8;
    localparam int ROWS  = 1 << ROW_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sr_en = 1'b0;
    logic [2:0]       pa_code = 3'd0;
    logic [1:0]       temp_code = 2'd0;
    logic             ref_stb;
    logic [1:0]       ref_bank;
    logic [ROW_W-1:0] ref_row;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sr_pasr_ctrl #(.ROW_W(ROW_W), .BASE_TICKS(BASE)) u_dut (
        .clk(clk), .rst(rst), .sr_en(sr_en), .pa_code(pa_code),
        .temp_code(temp_code), .ref_stb(ref_stb), .ref_bank(ref_bank),
        .ref_row(ref_row)
    );

    function automatic int span_of(logic [2:0] c);
        case (c)
            3'd1: return 2 * ROWS;
            3'd2: return ROWS;
            3'd3: return ROWS / 2;
            3'd4: return ROWS / 4;
            default: return 4 * ROWS;
        endcase
    endfunction

    function automatic int period_of(logic [1:0] t);
        case (t)
            2'd0: return 4 * BASE;
            2'd1: return 2 * BASE;
            2'd2: return BASE;
            default: return BASE / 2;
        endcase
    endfunction

    function automatic int addr_now();
        return int'({ref_bank, ref_row});
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_stb(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!ref_stb && gap < 1000);
    endtask

    // Cycle model built from the requirements
    int m_t = 0, m_pos = 0, m_addr = 0;
    bit m_stb = 0;
    always @(posedge clk) begin
        int eff;
        if (rst) begin
            m_t = 0; m_pos = 0; m_addr = 0; m_stb = 0;
        end else if (sr_en) begin
            if (m_t >= period_of(temp_code) - 1) begin
                m_t = 0;
                eff = (m_pos >= span_of(pa_code)) ? 0 : m_pos;
                m_stb = 1;
                m_addr = eff;
                m_pos = (eff + 1 >= span_of(pa_code)) ? 0 : eff + 1;
            end else begin
                m_t++;
                m_stb = 0;
            end
        end else begin
            m_t = 0;
            m_stb = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(ref_stb == m_stb, "R6", int'(ref_stb), int'(m_stb));
            if (m_stb) chk(addr_now() == m_addr, "R2", addr_now(), m_addr);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int gap;
        int a;
        void'($urandom(32'h5A17));

        // R1 reset state
        step(3);
        chk(ref_stb == 1'b0, "R1", int'(ref_stb), 0);
        chk(addr_now() == 0, "R1", addr_now(), 0);
        rst = 1'b0;
        step(1);
        chk(ref_stb == 1'b0 && addr_now() == 0, "R1", addr_now(), 0);

        // Sixteenth region, hottest band: walk and wrap
        pa_code = 3'd4; temp_code = 2'd3; sr_en = 1'b1;
        wait_stb(gap);
        chk(gap == BASE / 2, "R6", gap, BASE / 2);
        for (int i = 0; i < 20; i++) begin
            if (i < 16) chk(addr_now() == i, "R3", addr_now(), i);
            else        chk(addr_now() == i % 16, "R4", addr_now(), i % 16);
            wait_stb(gap);
            chk(gap == BASE / 2, "R6", gap, BASE / 2);
        end

        // Period per temperature band
        pa_code = 3'd0;
        for (int t = 0; t < 4; t++) begin
            temp_code = 2'(t);
            wait_stb(gap);
            wait_stb(gap);
            chk(gap == period_of(2'(t)), "R6", gap, period_of(2'(t)));
        end

        // Exit, hold, re-entry
        a = addr_now();
        sr_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            chk(ref_stb == 1'b0, "R8", int'(ref_stb), 0);
            chk(addr_now() == a, "R10", addr_now(), a);
        end
        sr_en = 1'b1;
        wait_stb(gap);
        chk(gap == period_of(temp_code), "R8", gap, period_of(temp_code));
        chk(addr_now() == (a + 1) % (4 * ROWS), "R9", addr_now(), (a + 1) % (4 * ROWS));

        // Narrowing leaves position outside region
        temp_code = 2'd3;
        do wait_stb(gap); while (addr_now() < 2 * ROWS);
        pa_code = 3'd2;
        wait_stb(gap);
        chk(addr_now() == 0, "R5", addr_now(), 0);
        wait_stb(gap);
        chk(addr_now() == 1, "R3", addr_now(), 1);

        // Temperature change mid-interval
        sr_en = 1'b0; step(2);
        pa_code = 3'd0; temp_code = 2'd0; sr_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1);
            chk(ref_stb == 1'b0, "R7", int'(ref_stb), 0);
        end
        temp_code = 2'd3;
        step(1);
        chk(ref_stb == 1'b1, "R7", int'(ref_stb), 1);

        // Random segments checked against the model
        for (int s = 0; s < 400; s++) begin
            sr_en     = ($urandom % 4) != 0;
            pa_code   = 3'($urandom % 8);
            temp_code = 2'($urandom % 4);
            step(1 + int'($urandom % 60));
        end

        finish_run();
    end

endmodule